// File: doc/BRIEF.md
# CAN Transmit Queue Controller

This block sits between a host that produces outgoing CAN messages and a bit-level frame transmitter. The host writes whole messages into an eight-entry transmit queue, each labelled with a tag of its own choosing. A small control machine presents the head message to the transmitter through a request/outcome handshake. The transmitter reports one of three outcomes: the frame went out, a bus error occurred, or arbitration was lost. The controller then decides whether to retire the message, retry it or throw it away.

Release of queued messages is gated by a trigger. The trigger comes either from a dedicated enable pin or from a configuration bit. It works in one of two ways: a level that keeps frames flowing until the queue is drained, or an edge that lets exactly one message go. A one-shot setting turns off automatic retry. Clear and abort commands let the host cancel queued or in-flight work. Every frame that completes cleanly leaves a record of its tag and the timestamp input in a separate eight-entry history queue, which the host reads at leisure.

Top module: `can_txq`

## Requirements
- R1: After reset the transmit queue is empty (`txf_empty`=1, `txf_full`=0), `overflow`, `hist_valid`, `busy` and `tx_req` are 0.
- R2: Messages leave in the order they were pushed; while `tx_req` is high, `tx_msg` carries the head message and the queue is not empty; `txf_full` rises when 8 messages are held.
- R3: A push while the queue holds 8 messages is discarded, and it sets `overflow`, which stays set until a clear command.
- R4: In continuous mode (`cfg_single`=0) frames are requested back to back while the trigger is high and the queue is non-empty. With the trigger low no new request starts, but a frame already requested still completes.
- R5: In single mode (`cfg_single`=1) each rising edge of the trigger releases exactly one message. Retries of that message need no further edge.
- R6: The trigger is `tx_en_pin` when `cfg_use_pin`=1 and `cfg_enable` otherwise; the unselected source has no effect.
- R7: With `cfg_one_shot`=0, a frame ending in `tx_err` or `tx_lost` leaves its message at the head. It is requested again after one idle cycle and makes no history entry.
- R8: With `cfg_one_shot`=1, a frame ending in `tx_err` or `tx_lost` discards its message without a history entry, and the next message follows.
- R9: A frame ending in `tx_done` retires its message. It pushes the message's tag and the `stamp_now` value sampled in the same cycle as `tx_done` into the history queue. `hist_tag`/`hist_time` show the oldest record while `hist_valid`=1, and `hist_pop` removes it.
- R10: When the history queue already holds 8 records, a new record overwrites the oldest one.
- R11: `abort_req` during a frame takes effect when that frame ends: the message is dropped with no history entry, whatever the outcome. `abort_req` with no frame outstanding has no effect.
- R12: `clear_fifo` clears `overflow` at once and cancels a pending single-mode release. It empties the transmit queue at once when no frame is outstanding, or when the outstanding frame ends, in which case the ending frame makes no history entry.
- R13: `busy` and `tx_req` are high from the request until the cycle in which `tx_done`, `tx_err` or `tx_lost` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Write one message into the transmit queue |
| push_msg | input | MSG_W | Message content |
| push_tag | input | TAG_W | Host tag attached to the message |
| clear_fifo | input | 1 | Clear-queue command pulse |
| abort_req | input | 1 | Abort-current-frame command pulse |
| cfg_use_pin | input | 1 | 1: trigger is `tx_en_pin`; 0: trigger is `cfg_enable` |
| tx_en_pin | input | 1 | External transmit enable |
| cfg_enable | input | 1 | Configuration transmit enable |
| cfg_single | input | 1 | 1: one message per trigger edge; 0: continuous |
| cfg_one_shot | input | 1 | Disable automatic retry |
| stamp_now | input | STAMP_W | Current time-tag counter value |
| tx_req | output | 1 | Frame request to the transmitter |
| tx_msg | output | MSG_W | Message to transmit |
| tx_done | input | 1 | Frame sent successfully |
| tx_err | input | 1 | Frame ended with a bus error |
| tx_lost | input | 1 | Frame lost arbitration |
| hist_pop | input | 1 | Remove oldest history record |
| hist_valid | output | 1 | History queue not empty |
| hist_tag | output | TAG_W | Tag of oldest history record |
| hist_time | output | STAMP_W | Timestamp of oldest history record |
| txf_empty | output | 1 | Transmit queue empty |
| txf_full | output | 1 | Transmit queue full |
| overflow | output | 1 | Sticky push-when-full flag |
| busy | output | 1 | A frame is outstanding |

## Verification
The checker runs on every cycle and covers the per-cycle invariants. A request never goes out from an empty queue, and a request is held until an outcome arrives. The overflow flag rises only on a push into a full queue and then stays set. A failed frame shrinks the queue by exactly one entry in one-shot mode and never shrinks it otherwise. A history record appears only after a successful completion. The directed scenarios show what depends on order and content: message order, the exact tag and timestamp of each record, release by level against release by edge, the choice of trigger source, the deferred effect of abort and clear, and which record the history queue loses when it wraps.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } txq_state_e;

    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/txq_ring.sv
module txq_ring
    import txq_pkg::*;
#(
    parameter int W         = 8,
    parameter int DEPTH     = 8,
    parameter bit OVERWRITE = 1'b0,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop, drop_old;

    assign empty  = (cnt == '0);
    assign full   = (cnt == CW'(DEPTH));
    assign count  = cnt;
    assign dout   = mem[rd_ptr];
    assign do_pop = pop && !empty;

    generate
        if (OVERWRITE) begin : g_overwrite
            assign do_push  = push;
            assign drop_old = push && full && !do_pop;
        end else begin : g_discard
            assign do_push  = push && (!full || do_pop);
            assign drop_old = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
            end
            if (do_pop || drop_old) begin
                rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
            end
            cnt <= cnt + CW'(do_push) - CW'(do_pop || drop_old);
        end
    end

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fifo_empty,
    input  logic trigger,
    input  logic single_mode,
    input  logic one_shot,
    input  logic abort_req,
    input  logic clear_req,
    input  logic tx_done,
    input  logic tx_err,
    input  logic tx_lost,
    output logic tx_req,
    output logic head_pop,
    output logic flush,
    output logic hist_push,
    output logic aborting
);

    txq_state_e state;
    logic trig_q, credit, abort_pend, clear_pend;
    logic frame_end, cancel, wipe, trig_rise, allowed, launch;

    always_comb begin
        frame_end = (state == ST_SEND) && (tx_done || tx_err || tx_lost);
        wipe      = clear_pend || clear_req;
        cancel    = abort_pend || abort_req || wipe;
        flush     = ((state == ST_IDLE) && clear_req) || (frame_end && wipe);
        head_pop  = frame_end && !wipe && (tx_done || one_shot || cancel);
        hist_push = (state == ST_SEND) && tx_done && !cancel;
        trig_rise = trigger && !trig_q;
        allowed   = single_mode ? credit : trigger;
        launch    = (state == ST_IDLE) && !fifo_empty && allowed && !clear_req;
    end

    assign tx_req   = (state == ST_SEND);
    assign aborting = abort_pend || clear_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            trig_q     <= 1'b0;
            credit     <= 1'b0;
            abort_pend <= 1'b0;
            clear_pend <= 1'b0;
        end else begin
            trig_q <= trigger;
            if (launch) begin
                state <= ST_SEND;
            end else if (frame_end) begin
                state <= ST_IDLE;
            end

            if (trig_rise) begin
                credit <= 1'b1;
            end else if (head_pop || flush || clear_req) begin
                credit <= 1'b0;
            end

            if (frame_end) begin
                abort_pend <= 1'b0;
                clear_pend <= 1'b0;
            end else if (state == ST_SEND) begin
                if (abort_req) abort_pend <= 1'b1;
                if (clear_req) clear_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_txq.sv
module can_txq
    import txq_pkg::*;
#(
    parameter int MSG_W      = 64,
    parameter int TAG_W      = 8,
    parameter int STAMP_W    = 16,
    parameter int TXQ_DEPTH  = 8,
    parameter int HIST_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_valid,
    input  logic [MSG_W-1:0]   push_msg,
    input  logic [TAG_W-1:0]   push_tag,
    input  logic               clear_fifo,
    input  logic               abort_req,
    input  logic               cfg_use_pin,
    input  logic               tx_en_pin,
    input  logic               cfg_enable,
    input  logic               cfg_single,
    input  logic               cfg_one_shot,
    input  logic [STAMP_W-1:0] stamp_now,
    output logic               tx_req,
    output logic [MSG_W-1:0]   tx_msg,
    input  logic               tx_done,
    input  logic               tx_err,
    input  logic               tx_lost,
    input  logic               hist_pop,
    output logic               hist_valid,
    output logic [TAG_W-1:0]   hist_tag,
    output logic [STAMP_W-1:0] hist_time,
    output logic               txf_empty,
    output logic               txf_full,
    output logic               overflow,
    output logic               busy
);

    localparam int TXF_CW = $clog2(TXQ_DEPTH + 1);
    localparam int HST_CW = $clog2(HIST_DEPTH + 1);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [MSG_W-1:0] msg;
    } q_entry_t;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [STAMP_W-1:0] stamp;
    } hist_rec_t;

    q_entry_t          q_in, q_head;
    hist_rec_t         h_in, h_out;
    logic [TXF_CW-1:0] txf_count;
    logic [HST_CW-1:0] hist_count;
    logic              head_pop, txf_flush, hist_push, aborting, trigger, hist_empty;

    assign q_in    = '{tag: push_tag, msg: push_msg};
    assign trigger = cfg_use_pin ? tx_en_pin : cfg_enable;

    txq_ring #(.W($bits(q_entry_t)), .DEPTH(TXQ_DEPTH), .OVERWRITE(1'b0)) u_txf (
        .clk(clk), .rst(rst), .flush(txf_flush),
        .push(push_valid), .din(q_in), .pop(head_pop),
        .dout(q_head), .empty(txf_empty), .full(txf_full), .count(txf_count)
    );

    txq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .fifo_empty(txf_empty), .trigger(trigger),
        .single_mode(cfg_single), .one_shot(cfg_one_shot),
        .abort_req(abort_req), .clear_req(clear_fifo),
        .tx_done(tx_done), .tx_err(tx_err), .tx_lost(tx_lost),
        .tx_req(tx_req), .head_pop(head_pop), .flush(txf_flush),
        .hist_push(hist_push), .aborting(aborting)
    );

    assign h_in = '{tag: q_head.tag, stamp: stamp_now};

    txq_ring #(.W($bits(hist_rec_t)), .DEPTH(HIST_DEPTH), .OVERWRITE(1'b1)) u_hist (
        .clk(clk), .rst(rst), .flush(1'b0),
        .push(hist_push), .din(h_in), .pop(hist_pop),
        .dout(h_out), .empty(hist_empty), .full(), .count(hist_count)
    );

    assign tx_msg     = q_head.msg;
    assign hist_valid = !hist_empty;
    assign hist_tag   = h_out.tag;
    assign hist_time  = h_out.stamp;
    assign busy       = tx_req;

    always_ff @(posedge clk) begin
        if (rst || clear_fifo) begin
            overflow <= 1'b0;
        end else if (push_valid && txf_full && !head_pop && !txf_flush) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/can_txq_chk.sv
module can_txq_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_req,
    input logic          tx_done,
    input logic          tx_err,
    input logic          tx_lost,
    input logic          txf_empty,
    input logic          txf_full,
    input logic          push_valid,
    input logic          clear_fifo,
    input logic          abort_req,
    input logic          cfg_one_shot,
    input logic          overflow,
    input logic          hist_valid,
    input logic          aborting,
    input logic [CW-1:0] txf_count
);

    p_req_has_msg_r2: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> !txf_empty);

    p_req_held_r13: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_done && !tx_err && !tx_lost) |=> tx_req);

    p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (overflow && !clear_fifo) |=> overflow);

    p_overflow_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(push_valid && txf_full));

    p_oneshot_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_req && (tx_err || tx_lost) && cfg_one_shot && !push_valid && !clear_fifo && !aborting)
        |=> (txf_count == $past(txf_count) - 1'b1));

    p_retry_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_req && (tx_err || tx_lost) && !tx_done && !cfg_one_shot && !abort_req && !clear_fifo && !aborting)
        |=> (txf_count >= $past(txf_count)));

    p_hist_from_done_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(hist_valid) |-> $past(tx_done && tx_req));

endmodule

bind can_txq can_txq_chk #(.CW(TXF_CW)) u_chk (
    .clk(clk), .rst(rst), .tx_req(tx_req), .tx_done(tx_done), .tx_err(tx_err),
    .tx_lost(tx_lost), .txf_empty(txf_empty), .txf_full(txf_full),
    .push_valid(push_valid), .clear_fifo(clear_fifo), .abort_req(abort_req),
    .cfg_one_shot(cfg_one_shot), .overflow(overflow), .hist_valid(hist_valid),
    .aborting(aborting), .txf_count(txf_count)
);

// File: tb/can_txq_tb.sv
module can_txq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 0, clear_fifo = 0, abort_req = 0;
    logic [63:0] push_msg = '0;
    logic [7:0]  push_tag = '0;
    logic        cfg_use_pin = 0, tx_en_pin = 0, cfg_enable = 0, cfg_single = 0, cfg_one_shot = 0;
    logic [15:0] stamp_now = '0;
    logic        tx_done = 0, tx_err = 0, tx_lost = 0, hist_pop = 0;
    logic        tx_req, hist_valid, txf_empty, txf_full, overflow, busy;
    logic [63:0] tx_msg;
    logic [7:0]  hist_tag;
    logic [15:0] hist_time;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    can_txq u_dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_msg(push_msg),
        .push_tag(push_tag), .clear_fifo(clear_fifo), .abort_req(abort_req),
        .cfg_use_pin(cfg_use_pin), .tx_en_pin(tx_en_pin), .cfg_enable(cfg_enable),
        .cfg_single(cfg_single), .cfg_one_shot(cfg_one_shot), .stamp_now(stamp_now),
        .tx_req(tx_req), .tx_msg(tx_msg), .tx_done(tx_done), .tx_err(tx_err),
        .tx_lost(tx_lost), .hist_pop(hist_pop), .hist_valid(hist_valid),
        .hist_tag(hist_tag), .hist_time(hist_time), .txf_empty(txf_empty),
        .txf_full(txf_full), .overflow(overflow), .busy(busy)
    );

    function automatic logic [63:0] mk(input logic [7:0] t);
        return {32'hC0DE_0000, 16'h5A00, t, ~t};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] t);
        push_valid = 1; push_msg = mk(t); push_tag = t;
        @(negedge clk);
        push_valid = 0;
    endtask

    task automatic pulse_clear();
        clear_fifo = 1; @(negedge clk); clear_fifo = 0;
    endtask

    task automatic wait_req(input logic [7:0] t, input string req);
        int k = 0;
        while (!tx_req && k < 40) begin
            @(negedge clk);
            k++;
        end
        check(tx_req, req, 64'(tx_req), 64'd1);
        check(tx_msg == mk(t), req, tx_msg, mk(t));
    endtask

    // outcome: 0 done, 1 error, 2 lost arbitration
    task automatic finish(input int outcome, input logic [15:0] st, input int dly);
        idle(dly);
        stamp_now = st;
        tx_done = (outcome == 0); tx_err = (outcome == 1); tx_lost = (outcome == 2);
        @(negedge clk);
        tx_done = 0; tx_err = 0; tx_lost = 0;
    endtask

    task automatic pop_hist(input logic [7:0] t, input logic [15:0] st, input string req);
        check(hist_valid, req, 64'(hist_valid), 64'd1);
        check(hist_tag == t, req, 64'(hist_tag), 64'(t));
        check(hist_time == st, req, 64'(hist_time), 64'(st));
        hist_pop = 1; @(negedge clk); hist_pop = 0;
    endtask

    task automatic t_reset();
        check(txf_empty && !txf_full, "R1", {62'd0, txf_full, txf_empty}, 64'd1);
        check(!overflow && !hist_valid && !busy && !tx_req, "R1",
              {60'd0, overflow, hist_valid, busy, tx_req}, 64'd0);
    endtask

    task automatic t_continuous();
        cfg_single = 0; cfg_enable = 0;
        push(8'h01); push(8'h02); push(8'h03);
        idle(3);
        check(!tx_req && !txf_empty, "R4 trigger low holds", 64'(tx_req), 64'd0);
        cfg_enable = 1;
        wait_req(8'h01, "R2 order");
        check(busy, "R13 busy", 64'(busy), 64'd1);
        finish(0, 16'h1111, 2);
        wait_req(8'h02, "R2 order");
        finish(0, 16'h2222, 0);
        wait_req(8'h03, "R4 back to back");
        cfg_enable = 0;
        finish(0, 16'h3333, 3);
        check(!busy && txf_empty, "R13 idle after end", 64'(busy), 64'd0);
        pop_hist(8'h01, 16'h1111, "R9");
        pop_hist(8'h02, 16'h2222, "R9");
        pop_hist(8'h03, 16'h3333, "R9");
        check(!hist_valid, "R9 drained", 64'(hist_valid), 64'd0);
        push(8'h04); push(8'h05);
        cfg_enable = 1;
        wait_req(8'h04, "R4");
        cfg_enable = 0;
        finish(0, 16'h0044, 1);
        idle(4);
        check(!tx_req && !txf_empty, "R4 stop on low", 64'(tx_req), 64'd0);
        cfg_enable = 1;
        wait_req(8'h05, "R4 resume");
        finish(0, 16'h0055, 0);
        cfg_enable = 0;
        pop_hist(8'h04, 16'h0044, "R9");
        pop_hist(8'h05, 16'h0055, "R9");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) push(8'h20 + 8'(i));
        check(txf_full && !overflow, "R2 full at 8", {62'd0, overflow, txf_full}, 64'd1);
        push(8'h2F);
        check(overflow && txf_full, "R3 overflow set", 64'(overflow), 64'd1);
        cfg_enable = 1;
        for (int i = 0; i < 8; i++) begin
            wait_req(8'h20 + 8'(i), "R3 ninth dropped");
            finish(0, 16'(i), 0);
        end
        cfg_enable = 0;
        idle(2);
        check(txf_empty && !tx_req, "R3 ninth dropped", 64'(txf_empty), 64'd1);
        check(overflow, "R3 sticky", 64'(overflow), 64'd1);
        pulse_clear();
        check(!overflow, "R12 clears overflow", 64'(overflow), 64'd0);
        for (int i = 0; i < 8; i++) pop_hist(8'h20 + 8'(i), 16'(i), "R9");
    endtask

    task automatic t_single();
        pulse_clear();
        cfg_single = 1; cfg_enable = 0;
        push(8'h30); push(8'h31);
        idle(2);
        cfg_enable = 1;
        wait_req(8'h30, "R5 one per edge");
        finish(0, 16'h0300, 1);
        idle(5);
        check(!tx_req && !txf_empty, "R5 only one released", 64'(tx_req), 64'd0);
        cfg_enable = 0; idle(1); cfg_enable = 1;
        wait_req(8'h31, "R5 second edge");
        finish(0, 16'h0310, 0);
        cfg_enable = 0; cfg_single = 0;
        pop_hist(8'h30, 16'h0300, "R5");
        pop_hist(8'h31, 16'h0310, "R5");
    endtask

    task automatic t_pin();
        cfg_use_pin = 1; cfg_enable = 1; tx_en_pin = 0;
        push(8'h40);
        idle(5);
        check(!tx_req, "R6 config bit ignored", 64'(tx_req), 64'd0);
        tx_en_pin = 1;
        wait_req(8'h40, "R6 pin releases");
        finish(0, 16'h4040, 0);
        tx_en_pin = 0; cfg_use_pin = 0; cfg_enable = 0;
        pop_hist(8'h40, 16'h4040, "R6");
    endtask

    task automatic t_retry();
        cfg_one_shot = 0;
        push(8'h50);
        cfg_enable = 1;
        wait_req(8'h50, "R7");
        finish(1, 16'h0001, 1);
        check(!tx_req && !hist_valid, "R7 idle gap, no record", {62'd0, tx_req, hist_valid}, 64'd0);
        wait_req(8'h50, "R7 same message retried");
        finish(2, 16'h0002, 0);
        wait_req(8'h50, "R7 retried after lost");
        finish(0, 16'h5050, 0);
        cfg_enable = 0;
        pop_hist(8'h50, 16'h5050, "R7");
    endtask

    task automatic t_oneshot();
        cfg_one_shot = 1;
        push(8'h60); push(8'h61);
        cfg_enable = 1;
        wait_req(8'h60, "R8");
        finish(2, 16'h0006, 0);
        check(!hist_valid, "R8 no record", 64'(hist_valid), 64'd0);
        wait_req(8'h61, "R8 next follows");
        finish(1, 16'h0007, 0);
        cfg_enable = 0;
        idle(2);
        check(txf_empty && !hist_valid, "R8 discarded", 64'(txf_empty), 64'd1);
        cfg_one_shot = 0;
    endtask

    task automatic t_abort();
        push(8'h70); push(8'h71);
        cfg_enable = 1;
        wait_req(8'h70, "R11");
        abort_req = 1; @(negedge clk); abort_req = 0;
        check(tx_req, "R11 frame continues", 64'(tx_req), 64'd1);
        finish(0, 16'h0777, 0);
        check(!hist_valid, "R11 no record", 64'(hist_valid), 64'd0);
        wait_req(8'h71, "R11 aborted message dropped");
        finish(0, 16'h0771, 0);
        cfg_enable = 0;
        pop_hist(8'h71, 16'h0771, "R11");
        push(8'h72);
        abort_req = 1; @(negedge clk); abort_req = 0;
        check(!txf_empty, "R11 idle abort no effect", 64'(txf_empty), 64'd0);
        cfg_enable = 1;
        wait_req(8'h72, "R11 idle abort no effect");
        finish(0, 16'h0772, 0);
        cfg_enable = 0;
        pop_hist(8'h72, 16'h0772, "R11");
    endtask

    task automatic t_clear();
        push(8'h80); push(8'h81); push(8'h82);
        pulse_clear();
        check(txf_empty, "R12 idle clear", 64'(txf_empty), 64'd1);
        push(8'h83); push(8'h84);
        cfg_enable = 1;
        wait_req(8'h83, "R12");
        pulse_clear();
        check(!txf_empty && tx_req, "R12 deferred", 64'(txf_empty), 64'd0);
        finish(0, 16'h0883, 0);
        idle(2);
        check(txf_empty && !tx_req && !hist_valid, "R12 flushed at frame end",
              {61'd0, txf_empty, tx_req, hist_valid}, 64'd4);
        cfg_enable = 0;
    endtask

    task automatic t_hist_wrap();
        cfg_enable = 1;
        for (int i = 0; i < 10; i++) begin
            push(8'h90 + 8'(i));
            wait_req(8'h90 + 8'(i), "R10");
            finish(0, 16'h0900 + 16'(i), 0);
        end
        cfg_enable = 0;
        for (int i = 2; i < 10; i++) pop_hist(8'h90 + 8'(i), 16'h0900 + 16'(i), "R10 oldest overwritten");
        check(!hist_valid, "R10 eight kept", 64'(hist_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        t_reset();
        t_continuous();
        t_overflow();
        t_single();
        t_pin();
        t_retry();
        t_oneshot();
        t_abort();
        t_clear();
        t_hist_wrap();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule